// File: doc/BRIEF.md
# Serial NAND Bring-Up Identify Sequencer

This block runs once per start request to bring a serial NAND device into a usable state. It does not drive the serial bus itself. It hands command frames to a frame engine and hands "wait until not busy" jobs to a ready poller. It steps through the bring-up sequence and stops at the first problem it finds.

The sequence runs in this order:

1. A device reset command.
2. A wait for ready.
3. Two identical two-byte identification reads, whose results must agree.
4. A lookup of the device code in a small table of known parts.
5. A feature-register write that clears every block-protection bit.

On success the block reports the manufacturer and device codes and the geometry of the part. The geometry covers page, erase-block, spare-area and chip size, together with the page and block address shifts. On failure it reports an error code that tells the four failure kinds apart.

A system controller pulses `start` after power-up and waits for `busy` to fall. It then reads `init_ok`, or `init_fail` with `err_code`. The results stay in place until the next accepted start.

Top module: `spinand_init_top`

## Requirements
- R1: While reset is held and right after it, `busy`, `init_ok`, `init_fail`, `err_code`, `fe_req` and `rp_req` are all 0.
- R2: A full successful run issues exactly four frames and one poll, in this order:
  - a reset frame with opcode 0xFF, one command byte and no data;
  - a ready poll;
  - two ID frames with opcode 0x9F, one command byte and two received bytes;
  - an unlock frame with command bytes 0x1F, 0xA0, one transmitted byte 0x00 and nothing received.
- R3: In an ID frame, the first received byte (`fe_rx[7:0]`) is the manufacturer code and the second (`fe_rx[15:8]`) is the device code. Both are reported from the first ID read whenever the two reads complete.
- R4: If the two 16-bit ID results differ in any bit, the run ends with `init_fail` and `err_code` = 2, and no unlock frame is sent.
- R5: Device codes 0xB4 and 0xA4 end in `init_ok` with `err_code` = 0. The reported geometry is 4096-byte pages, 262144-byte erase blocks, 256 spare bytes per page and a 512 MiB chip. The geometry outputs are 0 on any failed run.
- R6: Any other device code ends with `init_fail`, `err_code` = 3 and no unlock frame.
- R7: A ready poll that returns `rp_timeout` ends the run with `err_code` = 1, and no ID frame is sent.
- R8: A frame completed with `fe_fail` ends the run with `err_code` = 4, and no further frame or poll is issued.
- R9: `page_shift` and `block_shift` equal the index of the lowest set bit of the page size and of the block size (12 and 18 for the defaults).
- R10: A start while `busy` is ignored and the run goes on unchanged. After a run ends, every result output holds its value until the next start.
- R11: At most one of `fe_req` and `rp_req` is high at a time. Each request, with its frame fields, stays high and unchanged until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence when idle |
| busy | output | 1 | Sequence in progress |
| init_ok | output | 1 | Last run succeeded |
| init_fail | output | 1 | Last run failed |
| err_code | output | 3 | 0 none, 1 ready timeout, 2 ID mismatch, 3 unknown device, 4 bus error |
| man_id | output | 8 | Manufacturer code from the first ID read |
| dev_id | output | 8 | Device code from the first ID read |
| page_bytes | output | 32 | Page size in bytes |
| block_bytes | output | 32 | Erase-block size in bytes |
| spare_bytes | output | 32 | Spare bytes per page |
| chip_mib | output | 32 | Chip capacity in MiB |
| page_shift | output | 6 | Lowest set bit index of the page size |
| block_shift | output | 6 | Lowest set bit index of the block size |
| fe_req | output | 1 | Frame request, held until `fe_done` |
| fe_cmd0 | output | 8 | First command byte (opcode) |
| fe_cmd1 | output | 8 | Second command byte |
| fe_ncmd | output | 2 | Number of command bytes |
| fe_ntx | output | 2 | Number of data bytes to transmit |
| fe_tx | output | 8 | Data byte to transmit |
| fe_nrx | output | 2 | Number of data bytes to receive |
| fe_done | input | 1 | One-cycle frame completion |
| fe_fail | input | 1 | Frame bus error, valid with `fe_done` |
| fe_rx | input | 16 | Received bytes, first byte in [7:0], valid with `fe_done` |
| rp_req | output | 1 | Ready-poll request, held until `rp_done` |
| rp_done | input | 1 | One-cycle poll completion |
| rp_timeout | input | 1 | Poll timed out, valid with `rp_done` |

## Verification
Every result register is written on the clock edge that samples the final `fe_done`, `rp_done` or the lookup step. `busy` falls on that same edge, so all results are due in the cycle in which `busy` is first seen low.

The bench waits for `busy` to drop, sampling at falling edges, and only then compares results. It samples them again twelve idle cycles later.

The bench's responder records each frame at the falling edge where the request is first seen high. It raises the done pulse a set number of cycles later, varied from zero to three. This way request holding and frame order are checked whatever the subordinate latency.

// File: rtl/spinand_init_pkg.sv
package spinand_init_pkg;

  localparam int SZ_W = 32;
  localparam int SH_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_RDY,
    ST_ID1,
    ST_ID2,
    ST_MAP,
    ST_UNLK
  } step_t;

  typedef enum logic [2:0] {
    E_NONE        = 3'd0,
    E_RDY_TMO     = 3'd1,
    E_ID_MISMATCH = 3'd2,
    E_UNKNOWN     = 3'd3,
    E_BUS         = 3'd4
  } err_t;

  typedef struct packed {
    logic [SZ_W-1:0] page_b;
    logic [SZ_W-1:0] block_b;
    logic [SZ_W-1:0] spare_b;
    logic [SZ_W-1:0] chip_mib;
    logic [SH_W-1:0] page_sh;
    logic [SH_W-1:0] block_sh;
  } geom_t;

  // Index of the lowest set bit; 0 for a zero value.
  function automatic logic [SH_W-1:0] low_bit_pos(input logic [SZ_W-1:0] v);
    logic [SH_W-1:0] pos;
    pos = '0;
    for (int i = SZ_W - 1; i >= 0; i--) begin
      if (v[i]) pos = SH_W'(i);
    end
    return pos;
  endfunction

endpackage

// File: rtl/spinand_geom_lookup.sv
module spinand_geom_lookup
  import spinand_init_pkg::*;
#(
  parameter int                  N_CODES  = 2,
  parameter logic [N_CODES*8-1:0] CODES   = {8'hA4, 8'hB4},
  parameter logic [SZ_W-1:0]     PAGE_B   = 32'd4096,
  parameter logic [SZ_W-1:0]     BLOCK_B  = 32'd262144,
  parameter logic [SZ_W-1:0]     SPARE_B  = 32'd256,
  parameter logic [SZ_W-1:0]     CHIP_MIB = 32'd512
) (
  input  logic [7:0] dev_code,
  output logic       hit,
  output geom_t      geom
);

  logic [N_CODES-1:0] match;

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    assign match[g] = (dev_code == CODES[g*8 +: 8]);
  end

  geom_t known;

  always_comb begin
    known.page_b   = PAGE_B;
    known.block_b  = BLOCK_B;
    known.spare_b  = SPARE_B;
    known.chip_mib = CHIP_MIB;
    known.page_sh  = low_bit_pos(PAGE_B);
    known.block_sh = low_bit_pos(BLOCK_B);
  end

  assign hit  = |match;
  assign geom = hit ? known : '0;

endmodule

// File: rtl/spinand_id_compare.sv
module spinand_id_compare (
  input  logic [15:0] first_id,
  input  logic [15:0] second_id,
  output logic        same,
  output logic [7:0]  man,
  output logic [7:0]  dev
);

  // The first received byte sits in the low half of each read.
  assign same = (first_id == second_id);
  assign man  = first_id[7:0];
  assign dev  = first_id[15:8];

endmodule

// File: rtl/spinand_frame_build.sv
module spinand_frame_build
  import spinand_init_pkg::*;
#(
  parameter logic [7:0] RST_OP   = 8'hFF,
  parameter logic [7:0] ID_OP    = 8'h9F,
  parameter logic [7:0] SET_OP   = 8'h1F,
  parameter logic [7:0] LOCK_REG = 8'hA0,
  parameter logic [7:0] OPEN_VAL = 8'h00
) (
  input  step_t      step,
  output logic       fe_req,
  output logic [7:0] fe_cmd0,
  output logic [7:0] fe_cmd1,
  output logic [1:0] fe_ncmd,
  output logic [1:0] fe_ntx,
  output logic [7:0] fe_tx,
  output logic [1:0] fe_nrx,
  output logic       rp_req
);

  always_comb begin
    fe_req  = 1'b0;
    fe_cmd0 = '0;
    fe_cmd1 = '0;
    fe_ncmd = '0;
    fe_ntx  = '0;
    fe_tx   = '0;
    fe_nrx  = '0;
    rp_req  = 1'b0;
    unique case (step)
      ST_RST: begin
        fe_req  = 1'b1;
        fe_cmd0 = RST_OP;
        fe_ncmd = 2'd1;
      end
      ST_RDY: rp_req = 1'b1;
      ST_ID1, ST_ID2: begin
        fe_req  = 1'b1;
        fe_cmd0 = ID_OP;
        fe_ncmd = 2'd1;
        fe_nrx  = 2'd2;
      end
      ST_UNLK: begin
        fe_req  = 1'b1;
        fe_cmd0 = SET_OP;
        fe_cmd1 = LOCK_REG;
        fe_ncmd = 2'd2;
        fe_ntx  = 2'd1;
        fe_tx   = OPEN_VAL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/spinand_init_top.sv
module spinand_init_top
  import spinand_init_pkg::*;
#(
  parameter int                   N_CODES  = 2,
  parameter logic [N_CODES*8-1:0] CODES    = {8'hA4, 8'hB4},
  parameter logic [SZ_W-1:0]      PAGE_B   = 32'd4096,
  parameter logic [SZ_W-1:0]      BLOCK_B  = 32'd262144,
  parameter logic [SZ_W-1:0]      SPARE_B  = 32'd256,
  parameter logic [SZ_W-1:0]      CHIP_MIB = 32'd512,
  parameter logic [7:0]           RST_OP   = 8'hFF,
  parameter logic [7:0]           ID_OP    = 8'h9F,
  parameter logic [7:0]           SET_OP   = 8'h1F,
  parameter logic [7:0]           LOCK_REG = 8'hA0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            init_ok,
  output logic            init_fail,
  output logic [2:0]      err_code,
  output logic [7:0]      man_id,
  output logic [7:0]      dev_id,
  output logic [SZ_W-1:0] page_bytes,
  output logic [SZ_W-1:0] block_bytes,
  output logic [SZ_W-1:0] spare_bytes,
  output logic [SZ_W-1:0] chip_mib,
  output logic [SH_W-1:0] page_shift,
  output logic [SH_W-1:0] block_shift,
  output logic            fe_req,
  output logic [7:0]      fe_cmd0,
  output logic [7:0]      fe_cmd1,
  output logic [1:0]      fe_ncmd,
  output logic [1:0]      fe_ntx,
  output logic [7:0]      fe_tx,
  output logic [1:0]      fe_nrx,
  input  logic            fe_done,
  input  logic            fe_fail,
  input  logic [15:0]     fe_rx,
  output logic            rp_req,
  input  logic            rp_done,
  input  logic            rp_timeout
);

  step_t       step;
  err_t        err_q;
  geom_t       geom_q;
  geom_t       geom_lu;
  logic [15:0] id_a;
  logic [15:0] id_b;
  logic [7:0]  id_man;
  logic [7:0]  id_dev;
  logic        ok_q;
  logic        fail_q;

  // Named internal events used by the checker.
  logic id_same;
  logic code_hit;
  logic accept_start;

  assign accept_start = (step == ST_IDLE) && start;

  spinand_id_compare u_idcmp (
    .first_id  (id_a),
    .second_id (id_b),
    .same      (id_same),
    .man       (id_man),
    .dev       (id_dev)
  );

  spinand_geom_lookup #(
    .N_CODES  (N_CODES),
    .CODES    (CODES),
    .PAGE_B   (PAGE_B),
    .BLOCK_B  (BLOCK_B),
    .SPARE_B  (SPARE_B),
    .CHIP_MIB (CHIP_MIB)
  ) u_geom (
    .dev_code (id_dev),
    .hit      (code_hit),
    .geom     (geom_lu)
  );

  spinand_frame_build #(
    .RST_OP   (RST_OP),
    .ID_OP    (ID_OP),
    .SET_OP   (SET_OP),
    .LOCK_REG (LOCK_REG),
    .OPEN_VAL (8'h00)
  ) u_frame (
    .step    (step),
    .fe_req  (fe_req),
    .fe_cmd0 (fe_cmd0),
    .fe_cmd1 (fe_cmd1),
    .fe_ncmd (fe_ncmd),
    .fe_ntx  (fe_ntx),
    .fe_tx   (fe_tx),
    .fe_nrx  (fe_nrx),
    .rp_req  (rp_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      err_q  <= E_NONE;
      geom_q <= '0;
      id_a   <= '0;
      id_b   <= '0;
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      man_id <= '0;
      dev_id <= '0;
    end else begin
      unique case (step)
        ST_IDLE: begin
          if (accept_start) begin
            step   <= ST_RST;
            err_q  <= E_NONE;
            geom_q <= '0;
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
            man_id <= '0;
            dev_id <= '0;
          end
        end
        ST_RST: begin
          if (fe_done) begin
            if (fe_fail) begin
              step   <= ST_IDLE;
              fail_q <= 1'b1;
              err_q  <= E_BUS;
            end else begin
              step <= ST_RDY;
            end
          end
        end
        ST_RDY: begin
          if (rp_done) begin
            if (rp_timeout) begin
              step   <= ST_IDLE;
              fail_q <= 1'b1;
              err_q  <= E_RDY_TMO;
            end else begin
              step <= ST_ID1;
            end
          end
        end
        ST_ID1: begin
          if (fe_done) begin
            if (fe_fail) begin
              step   <= ST_IDLE;
              fail_q <= 1'b1;
              err_q  <= E_BUS;
            end else begin
              id_a <= fe_rx;
              step <= ST_ID2;
            end
          end
        end
        ST_ID2: begin
          if (fe_done) begin
            if (fe_fail) begin
              step   <= ST_IDLE;
              fail_q <= 1'b1;
              err_q  <= E_BUS;
            end else begin
              id_b <= fe_rx;
              step <= ST_MAP;
            end
          end
        end
        ST_MAP: begin
          man_id <= id_man;
          dev_id <= id_dev;
          if (!id_same) begin
            step   <= ST_IDLE;
            fail_q <= 1'b1;
            err_q  <= E_ID_MISMATCH;
          end else if (!code_hit) begin
            step   <= ST_IDLE;
            fail_q <= 1'b1;
            err_q  <= E_UNKNOWN;
          end else begin
            step <= ST_UNLK;
          end
        end
        ST_UNLK: begin
          if (fe_done) begin
            step <= ST_IDLE;
            if (fe_fail) begin
              fail_q <= 1'b1;
              err_q  <= E_BUS;
            end else begin
              ok_q   <= 1'b1;
              geom_q <= geom_lu;
            end
          end
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (step != ST_IDLE);
  assign init_ok     = ok_q;
  assign init_fail   = fail_q;
  assign err_code    = err_q;
  assign page_bytes  = geom_q.page_b;
  assign block_bytes = geom_q.block_b;
  assign spare_bytes = geom_q.spare_b;
  assign chip_mib    = geom_q.chip_mib;
  assign page_shift  = geom_q.page_sh;
  assign block_shift = geom_q.block_sh;

endmodule

// File: rtl/spinand_init_chk.sv
module spinand_init_chk
  import spinand_init_pkg::*;
#(
  parameter logic [7:0] SET_OP = 8'h1F
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            init_ok,
  input logic            init_fail,
  input logic [2:0]      err_code,
  input logic [7:0]      man_id,
  input logic [7:0]      dev_id,
  input logic [SZ_W-1:0] page_bytes,
  input logic [SZ_W-1:0] block_bytes,
  input logic [SH_W-1:0] page_shift,
  input logic [SH_W-1:0] block_shift,
  input logic            fe_req,
  input logic [7:0]      fe_cmd0,
  input logic            fe_done,
  input logic            rp_req,
  input logic            rp_done,
  input logic            id_same,
  input logic            code_hit
);

  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fe_req && rp_req));

  p_frame_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_req && !fe_done) |=> (fe_req && $stable(fe_cmd0)));

  p_poll_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && !rp_done) |=> rp_req);

  p_unlock_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_req && fe_cmd0 == SET_OP) |-> (id_same && code_hit));

  p_ok_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_ok |-> (err_code == 3'd0 && !init_fail && page_bytes != '0));

  p_fail_coded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_fail |-> (err_code != 3'd0 && !init_ok));

  p_shift_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_ok |-> ((page_bytes & ~(page_bytes - 1'b1)) == (SZ_W'(1) << page_shift)));

  p_shift_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_ok |-> ((block_bytes & ~(block_bytes - 1'b1)) == (SZ_W'(1) << block_shift)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(init_ok) && $stable(init_fail) &&
                           $stable(err_code) && $stable(man_id) &&
                           $stable(dev_id) && $stable(page_bytes)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(init_ok) && $stable(err_code));

endmodule

bind spinand_init_top spinand_init_chk #(
  .SET_OP (SET_OP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .init_ok     (init_ok),
  .init_fail   (init_fail),
  .err_code    (err_code),
  .man_id      (man_id),
  .dev_id      (dev_id),
  .page_bytes  (page_bytes),
  .block_bytes (block_bytes),
  .page_shift  (page_shift),
  .block_shift (block_shift),
  .fe_req      (fe_req),
  .fe_cmd0     (fe_cmd0),
  .fe_done     (fe_done),
  .rp_req      (rp_req),
  .rp_done     (rp_done),
  .id_same     (id_same),
  .code_hit    (code_hit)
);

// File: tb/spinand_init_top_tb_top.sv
module spinand_init_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, init_ok, init_fail;
  logic [2:0]  err_code;
  logic [7:0]  man_id, dev_id;
  logic [31:0] page_bytes, block_bytes, spare_bytes, chip_mib;
  logic [5:0]  page_shift, block_shift;
  logic        fe_req;
  logic [7:0]  fe_cmd0, fe_cmd1, fe_tx;
  logic [1:0]  fe_ncmd, fe_ntx, fe_nrx;
  logic        fe_done, fe_fail, rp_req, rp_done, rp_timeout;
  logic [15:0] fe_rx;

  always #4 clk = ~clk;

  spinand_init_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .init_ok(init_ok), .init_fail(init_fail), .err_code(err_code),
    .man_id(man_id), .dev_id(dev_id), .page_bytes(page_bytes),
    .block_bytes(block_bytes), .spare_bytes(spare_bytes), .chip_mib(chip_mib),
    .page_shift(page_shift), .block_shift(block_shift),
    .fe_req(fe_req), .fe_cmd0(fe_cmd0), .fe_cmd1(fe_cmd1), .fe_ncmd(fe_ncmd),
    .fe_ntx(fe_ntx), .fe_tx(fe_tx), .fe_nrx(fe_nrx), .fe_done(fe_done),
    .fe_fail(fe_fail), .fe_rx(fe_rx), .rp_req(rp_req), .rp_done(rp_done),
    .rp_timeout(rp_timeout)
  );

  int checks = 0;
  int fails = 0;

  // Responder configuration and frame log.
  logic [15:0] cfg_id1, cfg_id2;
  int          cfg_bad = -1;
  bit          cfg_tmo = 1'b0;
  int          resp_dly = 1;
  int          nfr = 0;
  int          npoll = 0;
  int          nid = 0;
  int          cur_idx = 0;
  logic [7:0]  log_c0 [8];
  logic [7:0]  log_c1 [8];
  logic [7:0]  log_tx [8];
  logic [1:0]  log_nc [8];
  logic [1:0]  log_nt [8];
  logic [1:0]  log_nr [8];

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int lowbit(input longint v);
    int k = 0;
    while (k < 31 && ((v >> k) & 1) == 0) k++;
    return k;
  endfunction

  // Frame engine and ready poller model.
  initial begin
    fe_done = 0; fe_fail = 0; fe_rx = '0; rp_done = 0; rp_timeout = 0;
    forever begin
      @(negedge clk);
      if (fe_req) begin
        cur_idx = nfr;
        if (nfr < 8) begin
          log_c0[nfr] = fe_cmd0; log_c1[nfr] = fe_cmd1; log_tx[nfr] = fe_tx;
          log_nc[nfr] = fe_ncmd; log_nt[nfr] = fe_ntx; log_nr[nfr] = fe_nrx;
        end
        nfr++;
        repeat (resp_dly) @(negedge clk);
        if (fe_cmd0 == 8'h9F) begin
          fe_rx = (nid == 0) ? cfg_id1 : cfg_id2;
          nid++;
        end
        fe_fail = (cur_idx == cfg_bad);
        fe_done = 1'b1;
        @(negedge clk);
        fe_done = 1'b0; fe_fail = 1'b0; fe_rx = '0;
      end else if (rp_req) begin
        npoll++;
        repeat (resp_dly) @(negedge clk);
        rp_timeout = cfg_tmo;
        rp_done = 1'b1;
        @(negedge clk);
        rp_done = 1'b0; rp_timeout = 1'b0;
      end
    end
  end

  task automatic check_results(input string tag, input logic [15:0] a, input int e_err,
                               input bit e_reach);
    bit ok_exp = (e_err == 0);
    chk(err_code == 3'(e_err), {tag, " err_code"}, err_code, e_err);
    chk(init_ok == ok_exp && init_fail == !ok_exp, {tag, " ok/fail R5"},
        {init_ok, init_fail}, {ok_exp, !ok_exp});
    chk(man_id == (e_reach ? a[7:0] : 8'h0), {tag, " man_id R3"}, man_id, e_reach ? a[7:0] : 0);
    chk(dev_id == (e_reach ? a[15:8] : 8'h0), {tag, " dev_id R3"}, dev_id, e_reach ? a[15:8] : 0);
    chk(page_bytes == (ok_exp ? 32'd4096 : 0) && block_bytes == (ok_exp ? 32'd262144 : 0),
        {tag, " page/block R5"}, {page_bytes, block_bytes},
        ok_exp ? {32'd4096, 32'd262144} : 64'd0);
    chk(spare_bytes == (ok_exp ? 32'd256 : 0) && chip_mib == (ok_exp ? 32'd512 : 0),
        {tag, " spare/chip R5"}, {spare_bytes, chip_mib}, ok_exp ? {32'd256, 32'd512} : 64'd0);
    chk(page_shift == (ok_exp ? 6'(lowbit(4096)) : 0) &&
        block_shift == (ok_exp ? 6'(lowbit(262144)) : 0),
        {tag, " shifts R9"}, {page_shift, block_shift},
        ok_exp ? {6'(lowbit(4096)), 6'(lowbit(262144))} : 0);
  endtask

  task automatic run_seq(input string tag, input logic [15:0] a, input logic [15:0] b,
                         input int bad, input bit tmo, input bit extra);
    int e_err, e_frames, e_polls;
    bit e_reach;
    int guard = 0;
    cfg_id1 = a; cfg_id2 = b; cfg_bad = bad; cfg_tmo = tmo;
    nfr = 0; npoll = 0; nid = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    e_reach = 0; e_polls = 1;
    if (bad == 0)       begin e_err = 4; e_frames = 1; e_polls = 0; end
    else if (tmo)       begin e_err = 1; e_frames = 1; end
    else if (bad == 1)  begin e_err = 4; e_frames = 2; end
    else if (bad == 2)  begin e_err = 4; e_frames = 3; end
    else begin
      e_reach = 1;
      if (a != b)                                        begin e_err = 2; e_frames = 3; end
      else if (!(a[15:8] == 8'hB4 || a[15:8] == 8'hA4))  begin e_err = 3; e_frames = 3; end
      else if (bad == 3)                                 begin e_err = 4; e_frames = 4; end
      else                                               begin e_err = 0; e_frames = 4; end
    end
    // R4 R6 R7 R8: frame and poll counts show where the run stopped
    chk(nfr == e_frames && npoll == e_polls, {tag, " frames/polls R8"},
        {nfr[15:0], npoll[15:0]}, {e_frames[15:0], e_polls[15:0]});
    check_results(tag, a, e_err, e_reach);
    if (e_err == 0) begin
      chk(log_c0[0] == 8'hFF && log_nc[0] == 2'd1 && log_nt[0] == 0 && log_nr[0] == 0,
          {tag, " reset frame R2"}, log_c0[0], 8'hFF);
      chk(log_c0[1] == 8'h9F && log_c0[2] == 8'h9F && log_nr[1] == 2'd2 &&
          log_nr[2] == 2'd2 && log_nc[1] == 2'd1, {tag, " id frames R2"},
          {log_c0[1], log_c0[2]}, 16'h9F9F);
      chk(log_c0[3] == 8'h1F && log_c1[3] == 8'hA0 && log_nc[3] == 2'd2 &&
          log_nt[3] == 2'd1 && log_tx[3] == 8'h00 && log_nr[3] == 0,
          {tag, " unlock frame R2"}, {log_c0[3], log_c1[3], log_tx[3]}, 24'h1FA000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !init_ok && !init_fail && err_code == 0 && !fe_req && !rp_req,
        "reset state R1", {busy, init_ok, init_fail, err_code, fe_req, rp_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !init_ok && !init_fail && err_code == 0 && !fe_req && !rp_req,
        "after reset R1", {busy, init_ok, init_fail, err_code, fe_req, rp_req}, 0);

    resp_dly = 2;
    run_seq("known B4 R5", 16'hB4C8, 16'hB4C8, -1, 0, 0);
    // R10: outputs hold while idle
    repeat (12) @(negedge clk);
    check_results("hold R10", 16'hB4C8, 0, 1);
    run_seq("known A4 with extra start R10", 16'hA42C, 16'hA42C, -1, 0, 1);
    run_seq("dev byte mismatch R4", 16'hB4C8, 16'hA4C8, -1, 0, 0);
    run_seq("man byte mismatch R4", 16'hB4C8, 16'hB4C9, -1, 0, 0);
    run_seq("unknown code R6", 16'h33C8, 16'h33C8, -1, 0, 0);
    run_seq("ready timeout R7", 16'hB4C8, 16'hB4C8, -1, 1, 0);
    for (int f = 0; f < 4; f++) begin
      run_seq("bus error R8", 16'hB4C8, 16'hB4C8, f, 0, 0);
    end
    for (int d = 0; d < 256; d++) begin
      resp_dly = d % 4;
      run_seq("code sweep R5 R6", {d[7:0], 8'(255 - d)}, {d[7:0], 8'(255 - d)}, -1, 0, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule